// File: doc/BRIEF.md
# Quadword Pair Load Sequencer

This block carries out a 128-bit load into a pair of adjacent general registers. An even register number, an effective address and an endian mode bit are presented together with a start pulse. The block then makes two 64-bit reads over a simple request/ready port. The first read goes to the 16-byte-aligned base and the second to base+8. Once both doublewords are held, the block writes them to the register file on two consecutive cycles, even register first and odd register second. It then pulses done.

The endian mode decides which doubleword goes to which register. In big-endian mode the even register gets the doubleword at the base and the odd register gets the one at base+8, both unchanged. In little-endian mode the pairing is crossed and each doubleword has its bytes reversed. An odd target number cannot name a pair, so it is rejected with a one-cycle invalid pulse and causes no traffic. The effective address is computed upstream and the register file sits downstream.

Top module: `qlp_quad_load`

## Requirements
- R1: While reset is held and in the first cycle after it, rd_req_o, wr_en_o, done_o and invalid_o are all 0.
- R2: An accepted start raises rd_req_o in the next cycle. The first read address is the aligned base, and the second read, issued after the first is accepted, is the base plus 8.
- R3: The four least significant bits of ea_i are ignored: the base is ea_i with bits [3:0] cleared, so the two read addresses always end in hex 0 and hex 8.
- R4: With little_end_i = 0, the first write carries the doubleword read from the base and the second write carries the doubleword from base+8, both unchanged.
- R5: With little_end_i = 1, the first write carries the doubleword from base+8 and the second carries the doubleword from the base, each byte-reversed (result byte k, bits [8k+7:8k], equals source byte 7-k).
- R6: The first write targets even_reg_i and the second write targets even_reg_i + 1, in the cycle right after the first.
- R7: No register write occurs before both reads have completed, and rd_req_o is 0 whenever wr_en_o is 1.
- R8: done_o is high for exactly one cycle, the cycle right after the second write.
- R9: A start with even_reg_i[0] = 1 makes invalid_o high for exactly the next cycle, with no read, no write and no done pulse.
- R10: start_i has no effect unless the sequencer is idle, and that includes the cycle in which done_o is high.
- R11: While rd_req_o is 1 and rd_ready_i is 0, rd_req_o stays 1 and rd_addr_o holds its value in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a pair load (sampled only when idle) |
| ea_i | input | ADDR_W | Effective address of the quadword |
| even_reg_i | input | REG_W | Even target register number |
| little_end_i | input | 1 | 1 = little-endian pairing with byte reversal |
| rd_addr_o | output | ADDR_W | Read address |
| rd_req_o | output | 1 | Read request, held until accepted |
| rd_ready_i | input | 1 | Read accepted; rd_data_i is valid in the same cycle |
| rd_data_i | input | DATA_W | Read data |
| wr_en_o | output | 1 | Register write strobe |
| wr_reg_o | output | REG_W | Register number being written |
| wr_data_o | output | DATA_W | Register write data |
| done_o | output | 1 | One-cycle completion pulse |
| invalid_o | output | 1 | One-cycle pulse for an odd target number |

## Verification
The bench sets ADDR_W to 32 and leaves REG_W at 5 and DATA_W at 64. With this address width, an effective address of all ones can be used to show that alignment never carries into the upper address bits. With REG_W at 5, the last pair, 30 and 31, can be written, along with odd targets such as 7 and 31. The byte-reversal stage is kept in its default place, on the write path, so the little-endian crossing and reversal are exercised through that variant. A stalling ready pattern holds requests open to test the hold rule.

// File: rtl/qlp_pkg.sv
package qlp_pkg;

   typedef enum logic [2:0] {
      QS_IDLE  = 3'd0,
      QS_READ0 = 3'd1,
      QS_READ1 = 3'd2,
      QS_WRITE = 3'd3,
      QS_DONE  = 3'd4
   } qlp_state_e;

endpackage

// File: rtl/qlp_byte_rev.sv
module qlp_byte_rev #(
   parameter int DATA_W = 64,
   parameter int BYTE_W = 8
) (
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam int NBYTES = DATA_W / BYTE_W;

   generate
      if (DATA_W % BYTE_W != 0) begin : g_bad_width
         $error("qlp_byte_rev: DATA_W must be a whole number of bytes");
      end
   endgenerate

   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      assign dout[b*BYTE_W +: BYTE_W] = din[(NBYTES-1-b)*BYTE_W +: BYTE_W];
   end

endmodule

// File: rtl/qlp_pair_buf.sv
module qlp_pair_buf #(
   parameter int DATA_W          = 64,
   parameter int BYTE_W          = 8,
   parameter bit SWAP_AT_CAPTURE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_lo_i,
   input  logic              cap_hi_i,
   input  logic              little_end_i,
   input  logic              sel_odd_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic [DATA_W-1:0] wr_data_o
);
   logic [DATA_W-1:0] hold_lo_q, hold_hi_q;
   logic [DATA_W-1:0] pick;
   logic              take_hi;

   // even <- hi in LE, lo in BE; odd is the other one
   assign take_hi = little_end_i ^ sel_odd_i;
   assign pick    = take_hi ? hold_hi_q : hold_lo_q;

   generate
      if (SWAP_AT_CAPTURE) begin : g_swap_in
         logic [DATA_W-1:0] rd_rev, cap_val;
         qlp_byte_rev #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_rev (
            .din  (rd_data_i),
            .dout (rd_rev)
         );
         assign cap_val = little_end_i ? rd_rev : rd_data_i;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hold_lo_q <= '0;
               hold_hi_q <= '0;
            end else begin
               if (cap_lo_i) hold_lo_q <= cap_val;
               if (cap_hi_i) hold_hi_q <= cap_val;
            end
         end
         assign wr_data_o = pick;
      end else begin : g_swap_out
         logic [DATA_W-1:0] pick_rev;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hold_lo_q <= '0;
               hold_hi_q <= '0;
            end else begin
               if (cap_lo_i) hold_lo_q <= rd_data_i;
               if (cap_hi_i) hold_hi_q <= rd_data_i;
            end
         end
         qlp_byte_rev #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_rev (
            .din  (pick),
            .dout (pick_rev)
         );
         assign wr_data_o = little_end_i ? pick_rev : pick;
      end
   endgenerate

endmodule

// File: rtl/qlp_ctrl.sv
module qlp_ctrl
   import qlp_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic reg_lsb_i,
   input  logic rd_ready_i,
   output logic accept_o,
   output logic rd_req_o,
   output logic rd_hi_o,
   output logic cap_lo_o,
   output logic cap_hi_o,
   output logic wr_en_o,
   output logic wr_odd_o,
   output logic done_o,
   output logic invalid_o
);
   qlp_state_e state_q, state_d;
   logic       phase_q, phase_d;
   logic       invalid_q;

   assign accept_o = (state_q == QS_IDLE) && start_i && !reg_lsb_i;

   always_comb begin
      state_d = state_q;
      phase_d = phase_q;
      unique case (state_q)
         QS_IDLE:  if (accept_o) state_d = QS_READ0;
         QS_READ0: if (rd_ready_i) state_d = QS_READ1;
         QS_READ1: if (rd_ready_i) begin
                      state_d = QS_WRITE;
                      phase_d = 1'b0;
                   end
         QS_WRITE: if (phase_q) begin
                      state_d = QS_DONE;
                      phase_d = 1'b0;
                   end else begin
                      phase_d = 1'b1;
                   end
         QS_DONE:  state_d = QS_IDLE;
         default:  state_d = QS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= QS_IDLE;
         phase_q   <= 1'b0;
         invalid_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         phase_q   <= phase_d;
         invalid_q <= (state_q == QS_IDLE) && start_i && reg_lsb_i;
      end
   end

   assign rd_req_o  = (state_q == QS_READ0) || (state_q == QS_READ1);
   assign rd_hi_o   = (state_q == QS_READ1);
   assign cap_lo_o  = (state_q == QS_READ0) && rd_ready_i;
   assign cap_hi_o  = (state_q == QS_READ1) && rd_ready_i;
   assign wr_en_o   = (state_q == QS_WRITE);
   assign wr_odd_o  = phase_q;
   assign done_o    = (state_q == QS_DONE);
   assign invalid_o = invalid_q;

   // R10
   read0_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == QS_READ0) |-> ($past(state_q) == QS_IDLE || $past(state_q) == QS_READ0));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R6
   write_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && !wr_odd_o) |=> (wr_en_o && wr_odd_o));

   // R9
   invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      invalid_o |-> (!rd_req_o && !wr_en_o && !done_o));

endmodule

// File: rtl/qlp_quad_load.sv
module qlp_quad_load #(
   parameter int DATA_W          = 64,
   parameter int ADDR_W          = 64,
   parameter int REG_W           = 5,
   parameter int BYTE_W          = 8,
   parameter bit SWAP_AT_CAPTURE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] ea_i,
   input  logic [REG_W-1:0]  even_reg_i,
   input  logic              little_end_i,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic              rd_req_o,
   input  logic              rd_ready_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              wr_en_o,
   output logic [REG_W-1:0]  wr_reg_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              done_o,
   output logic              invalid_o
);
   localparam int DW_BYTES  = DATA_W / BYTE_W;
   localparam int QW_BYTES  = 2 * DW_BYTES;
   localparam int ALIGN_LSB = $clog2(QW_BYTES);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(ADDR_W'(QW_BYTES - 1));
   localparam logic [ADDR_W-1:0] HI_OFF     = ADDR_W'(DW_BYTES);

   generate
      if (DATA_W % BYTE_W != 0) begin : g_bad_data
         $error("qlp_quad_load: DATA_W must be a multiple of BYTE_W");
      end
      if ((1 << ALIGN_LSB) != QW_BYTES) begin : g_bad_pow2
         $error("qlp_quad_load: bytes per quadword must be a power of two");
      end
      if (ADDR_W <= ALIGN_LSB) begin : g_bad_addr
         $error("qlp_quad_load: ADDR_W too narrow for quadword alignment");
      end
      if (REG_W < 1) begin : g_bad_reg
         $error("qlp_quad_load: REG_W must be at least 1");
      end
   endgenerate

   logic              accept, rd_hi, cap_lo, cap_hi, wr_odd;
   logic [ADDR_W-1:0] base_q;
   logic [REG_W-1:0]  even_q;
   logic              le_q;

   qlp_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .reg_lsb_i  (even_reg_i[0]),
      .rd_ready_i (rd_ready_i),
      .accept_o   (accept),
      .rd_req_o   (rd_req_o),
      .rd_hi_o    (rd_hi),
      .cap_lo_o   (cap_lo),
      .cap_hi_o   (cap_hi),
      .wr_en_o    (wr_en_o),
      .wr_odd_o   (wr_odd),
      .done_o     (done_o),
      .invalid_o  (invalid_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         even_q <= '0;
         le_q   <= 1'b0;
      end else if (accept) begin
         base_q <= ea_i & ALIGN_MASK;
         even_q <= even_reg_i;
         le_q   <= little_end_i;
      end
   end

   assign rd_addr_o = base_q | (rd_hi ? HI_OFF : '0);
   assign wr_reg_o  = even_q | REG_W'(wr_odd);

   qlp_pair_buf #(
      .DATA_W          (DATA_W),
      .BYTE_W          (BYTE_W),
      .SWAP_AT_CAPTURE (SWAP_AT_CAPTURE)
   ) u_buf (
      .clk          (clk),
      .rst_n        (rst_n),
      .cap_lo_i     (cap_lo),
      .cap_hi_i     (cap_hi),
      .little_end_i (le_q),
      .sel_odd_i    (wr_odd),
      .rd_data_i    (rd_data_i),
      .wr_data_o    (wr_data_o)
   );

   // R11
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_ready_i) |=> (rd_req_o && $stable(rd_addr_o)));

   // R3
   rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> (rd_addr_o[ALIGN_LSB-2:0] == '0));

   // R6
   wr_reg_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && !wr_reg_o[0]) |=> (wr_reg_o == REG_W'($past(wr_reg_o) + 1'b1)));

   // R7
   wr_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> !rd_req_o);

endmodule

// File: tb/qlp_quad_load_tb.sv
module qlp_quad_load_tb;
   localparam int DATA_W = 64;
   localparam int ADDR_W = 32;
   localparam int REG_W  = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [ADDR_W-1:0] ea = '0;
   logic [REG_W-1:0]  even_reg = '0;
   logic              le = 1'b0;
   logic [ADDR_W-1:0] rd_addr;
   logic              rd_req;
   logic              rd_ready = 1'b0;
   logic [DATA_W-1:0] rd_data;
   logic              wr_en;
   logic [REG_W-1:0]  wr_reg;
   logic [DATA_W-1:0] wr_data;
   logic              done;
   logic              invalid;

   always #4 clk = ~clk;

   qlp_quad_load #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_W(REG_W)) u_dut (
      .clk (clk), .rst_n (rst_n), .start_i (start), .ea_i (ea),
      .even_reg_i (even_reg), .little_end_i (le),
      .rd_addr_o (rd_addr), .rd_req_o (rd_req), .rd_ready_i (rd_ready),
      .rd_data_i (rd_data), .wr_en_o (wr_en), .wr_reg_o (wr_reg),
      .wr_data_o (wr_data), .done_o (done), .invalid_o (invalid)
   );

   function automatic logic [63:0] mem_word(input logic [31:0] a);
      return {a ^ 32'hC3A5_1E0F, a[15:0], ~a[31:16]};
   endfunction

   function automatic logic [63:0] rev8(input logic [63:0] d);
      logic [63:0] r;
      for (int i = 0; i < 8; i++) r[i*8 +: 8] = d[(7-i)*8 +: 8];
      return r;
   endfunction

   assign rd_data = mem_word(rd_addr);

   int total = 0;
   int fails = 0;
   int cyc = 0;
   int last_wr_cyc = -10;
   int reads_seen = 0;
   bit stall_mode = 1'b0;
   logic [7:0] lfsr = 8'hA7;
   string data_tag = "R4";
   bit hold_pend = 1'b0;
   logic [ADDR_W-1:0] hold_addr = '0;

   logic [ADDR_W-1:0] exp_rd_q[$];
   logic [REG_W-1:0]  exp_reg_q[$];
   logic [DATA_W-1:0] exp_dat_q[$];

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] expv);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 60000) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 60000);
         summary();
         $finish;
      end
   end

   // responder and monitor: reads and writes
   always @(negedge clk) begin
      logic rdy;
      if (hold_pend) begin
         chk(rd_req && rd_addr == hold_addr, "R11 request held", {31'd0, rd_req, rd_addr}, {31'd0, 1'b1, hold_addr});
         hold_pend = 1'b0;
      end
      rdy = stall_mode ? (lfsr[0] ^ lfsr[3]) : 1'b1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rd_ready = rdy;
      if (rd_req && !rdy) begin
         hold_pend = 1'b1;
         hold_addr = rd_addr;
      end
      if (rd_req && rdy) begin
         if (exp_rd_q.size() == 0) begin
            chk(1'b0, "R2 unexpected read", 64'(rd_addr), 64'hX);
         end else begin
            logic [ADDR_W-1:0] ea_exp;
            ea_exp = exp_rd_q.pop_front();
            chk(rd_addr == ea_exp, "R2/R3 read address", 64'(rd_addr), 64'(ea_exp));
         end
         reads_seen++;
      end
      if (wr_en) begin
         chk(reads_seen == 2, "R7 write before both reads", 64'(reads_seen), 64'd2);
         if (exp_reg_q.size() == 0) begin
            chk(1'b0, "R6 unexpected write", 64'(wr_reg), 64'hX);
         end else begin
            logic [REG_W-1:0]  r_exp;
            logic [DATA_W-1:0] d_exp;
            r_exp = exp_reg_q.pop_front();
            d_exp = exp_dat_q.pop_front();
            chk(wr_reg == r_exp, "R6 write register", 64'(wr_reg), 64'(r_exp));
            chk(wr_data == d_exp, data_tag, wr_data, d_exp);
            if (wr_reg[0]) chk(last_wr_cyc == cyc - 1, "R6 consecutive writes", 64'(cyc), 64'(last_wr_cyc + 1));
         end
         last_wr_cyc = cyc;
      end
   end

   // driver: queues expectations, then launches the load
   // ign: 0 none, 1 extra start while busy, 2 extra start in the done cycle
   task automatic run_op(input logic [31:0] a, input logic [REG_W-1:0] r,
                         input bit lem, input int ign);
      logic [31:0] base;
      logic [63:0] dlo, dhi;
      base = a & ~32'hF;
      dlo  = mem_word(base);
      dhi  = mem_word(base | 32'h8);
      exp_rd_q.push_back(base);
      exp_rd_q.push_back(base | 32'h8);
      exp_reg_q.push_back(r);
      exp_reg_q.push_back(r + 1'b1);
      exp_dat_q.push_back(lem ? rev8(dhi) : dlo);
      exp_dat_q.push_back(lem ? rev8(dlo) : dhi);
      data_tag = lem ? "R5 little-endian data" : "R4 big-endian data";
      @(negedge clk);
      reads_seen = 0;
      start = 1'b1; ea = a; even_reg = r; le = lem;
      @(negedge clk);
      start = 1'b0; ea = ~a; even_reg = r ^ 5'd6; le = ~lem;
      chk(rd_req, "R2 request after start", 64'(rd_req), 64'd1);
      if (ign == 1) begin
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done) @(negedge clk);
      chk(last_wr_cyc == cyc - 1, "R8 done after odd write", 64'(cyc), 64'(last_wr_cyc + 1));
      chk(exp_reg_q.size() == 0 && exp_rd_q.size() == 0, "R6 all items produced",
          64'(exp_reg_q.size() + exp_rd_q.size()), 64'd0);
      if (ign == 2) begin
         start = 1'b1; even_reg = 5'd8; ea = a ^ 32'h100;
      end
      @(negedge clk);
      start = 1'b0;
      chk(!done, "R8 done single cycle", 64'(done), 64'd0);
      if (ign != 0) begin
         for (int k = 0; k < 4; k++) begin
            chk(!rd_req && !wr_en, "R10 start ignored when busy", {rd_req, wr_en}, 64'd0);
            @(negedge clk);
         end
      end
   endtask

   task automatic run_invalid(input logic [REG_W-1:0] r);
      @(negedge clk);
      start = 1'b1; even_reg = r; ea = 32'h2000_0000; le = 1'b0;
      @(negedge clk);
      start = 1'b0;
      chk(invalid, "R9 invalid raised", 64'(invalid), 64'd1);
      @(negedge clk);
      chk(!invalid, "R9 invalid single cycle", 64'(invalid), 64'd0);
      for (int k = 0; k < 5; k++) begin
         chk(!rd_req && !wr_en && !done, "R9 no activity", {rd_req, wr_en, done}, 64'd0);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!rd_req && !wr_en && !done && !invalid, "R1 outputs during reset",
          {rd_req, wr_en, done, invalid}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!rd_req && !wr_en && !done && !invalid, "R1 outputs after reset",
          {rd_req, wr_en, done, invalid}, 64'd0);

      run_op(32'h1000_0000, 5'd4, 1'b0, 0);
      run_op(32'h1000_0040, 5'd10, 1'b1, 0);
      stall_mode = 1'b1;
      run_op(32'h1234_567B, 5'd0, 1'b0, 0);   // R3 unaligned low bits
      run_op(32'hFFFF_FFFF, 5'd30, 1'b1, 0);  // R3 top of address space
      run_invalid(5'd7);
      run_invalid(5'd31);
      run_op(32'h0ABC_0020, 5'd12, 1'b0, 1);  // R10 start while reading
      run_op(32'h0ABC_0130, 5'd2, 1'b1, 2);   // R10 start in done cycle
      for (int i = 0; i < 16; i++) begin
         stall_mode = i[1];
         run_op(32'h0100_0000 + i * 32'h0000_1357, REG_W'((i * 6) % 32) & ~5'd1, i[0], 0);
      end
      repeat (4) @(negedge clk);
      summary();
      $finish;
   end

endmodule